// File: doc/BRIEF.md
# Four-State Snooping Coherence Controller

This block keeps a small direct-mapped table of line tags and coherence states for one cache and holds each line coherent with the other caches on a shared snooping bus. Lines can be Invalid, Shared, Exclusive or Modified. Internally the states are encoded Invalid = 2'b00, Shared = 2'b01, Exclusive = 2'b10 and Modified = 2'b11. The processor side issues one read or write at a time. The controller answers hits locally. On a miss or an upgrade it places a read (BusRd) or a read-for-ownership (BusRdX) request on the bus. While it does this it watches every bus transaction from other caches and updates its own lines in response.

The key feature is the fill decision on a read miss. A fixed number of cycles after its BusRd address phase, the controller samples the wired-OR shared line of the bus. If no other cache pulled the line, the fill is Exclusive, and a later write upgrades to Modified with no bus traffic. If the line was pulled, the fill is Shared. When the controller snoops a BusRd that hits one of its own valid lines, it drives its own contribution to the shared line. A Modified line raises a flush strobe when snooped, and an Exclusive line raises a cache-to-cache transfer strobe when snooped by a read. A miss that replaces a Modified victim requests a write-back. Data movement, memory and bus arbitration belong to the surrounding system.

The processor FSM has two states. FS_IDLE accepts a request and handles hits, upgrades and write misses within a single cycle. FS_RESP waits for the shared-line response of an outstanding BusRd. The line transitions are as follows:
- Processor side: I->E and I->S on a read miss, E->M silently, S->M by upgrade, I->M on a write miss.
- Snoop side: M->S and E->S on a snooped read, {M,E,S}->I on a snooped read-for-ownership.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid, so the first read of any address issues BusRd.
- R2: A read miss issues BusRd (`bus_req_valid`=1, `bus_req_rdx`=0) in the cycle after acceptance. The controller samples `bus_shared_in` on the RSP_LAT-th clock edge after acceptance and fills the line as Exclusive if it is 0 or as Shared if it is 1. `cpu_done` pulses in the following cycle.
- R3: A read that hits a valid line pulses `cpu_done` in the cycle after acceptance, with no bus request and no state change.
- R4: A write that hits an Exclusive or Modified line moves the line to Modified and pulses `cpu_done` with no bus request.
- R5: A write that hits a Shared line, or that misses, issues BusRdX (`bus_req_rdx`=1) and pulses `cpu_done` in the cycle after acceptance, leaving the line Modified.
- R6: A snooped BusRd that hits a valid line raises `snp_shared` in the next cycle.
- R7: A snooped BusRd that hits a Modified line raises `snp_flush` in the next cycle and moves the line to Shared.
- R8: A snooped BusRd that hits an Exclusive line raises `snp_c2c` in the next cycle and moves the line to Shared. A Shared line raises neither strobe.
- R9: A snooped BusRdX that hits a valid line moves it to Invalid. If the line was Modified, `snp_flush` is raised in the next cycle.
- R10: A miss whose victim is Modified raises `wb_req` together with its bus request, with `wb_addr` set to the victim's address. Replacing an Exclusive or Shared victim is silent.
- R11: A snoop whose address misses, or that hits an Invalid line, raises no response strobe and changes no state.
- R12: A snoop has priority. `cpu_ready` is low while `snp_valid` is high or a BusRd is outstanding, and a processor request presented then is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request strobe, taken when cpu_ready is high |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Line address of the request |
| cpu_ready | output | 1 | Controller can accept a request this cycle |
| cpu_done | output | 1 | Request completed |
| bus_req_valid | output | 1 | Own bus transaction in its address phase |
| bus_req_rdx | output | 1 | 1 = BusRdX, 0 = BusRd |
| bus_req_addr | output | ADDR_W | Address of own bus transaction |
| bus_shared_in | input | 1 | Wired-OR shared line from the bus |
| snp_valid | input | 1 | Transaction from another cache seen on the bus |
| snp_rdx | input | 1 | Snooped type: 1 = BusRdX, 0 = BusRd |
| snp_addr | input | ADDR_W | Snooped line address |
| snp_shared | output | 1 | This cache's contribution to the shared line |
| snp_flush | output | 1 | Modified data must be flushed to the bus |
| snp_c2c | output | 1 | Clean block supplied cache-to-cache |
| wb_req | output | 1 | Write-back request for an evicted Modified line |
| wb_addr | output | ADDR_W | Address of the evicted line |

## Verification
The hardest states to reach are those in which a snooped transaction meets a line in one particular state. Examples are a Modified line that was reached silently from Exclusive, or a Shared line that was filled because another cache answered on the shared line. To reach them, the stimulus first builds each state through the processor side, with chosen `bus_shared_in` values during the fill window, and only then injects the snoop. Several addresses that map to the same index are used to force Modified and clean evictions. A processor request presented in the same cycle as a snoop checks that the snoop takes priority.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
    typedef enum logic [1:0] {
        LN_I = 2'b00,
        LN_S = 2'b01,
        LN_E = 2'b10,
        LN_M = 2'b11
    } line_st_t;

    typedef enum logic {
        FS_IDLE = 1'b0,
        FS_RESP = 1'b1
    } fsm_st_t;
endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
    import mesi_pkg::*;
#(
    parameter int SETS  = 8,
    parameter int TAG_W = 5,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    // processor-side read port
    input  logic [IDX_W-1:0] a_idx,
    output line_st_t         a_st,
    output logic [TAG_W-1:0] a_tag,
    // snoop-side read port
    input  logic [IDX_W-1:0] b_idx,
    output line_st_t         b_st,
    output logic [TAG_W-1:0] b_tag,
    // snoop-side write (state only)
    input  logic             b_we,
    input  line_st_t         b_wst,
    // processor-side write
    input  logic             a_we,
    input  logic [IDX_W-1:0] a_widx,
    input  line_st_t         a_wst,
    input  logic             a_wtag_en,
    input  logic [TAG_W-1:0] a_wtag
);
    line_st_t         st_q  [SETS];
    logic [TAG_W-1:0] tag_q [SETS];

    assign a_st  = st_q[a_idx];
    assign a_tag = tag_q[a_idx];
    assign b_st  = st_q[b_idx];
    assign b_tag = tag_q[b_idx];

    for (genvar g = 0; g < SETS; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q[g]  <= LN_I;
                tag_q[g] <= '0;
            end else begin
                // processor write wins; a snoop never hits a line being filled
                if (a_we && a_widx == IDX_W'(g)) begin
                    st_q[g] <= a_wst;
                    if (a_wtag_en) tag_q[g] <= a_wtag;
                end else if (b_we && b_idx == IDX_W'(g)) begin
                    st_q[g] <= b_wst;
                end
            end
        end
    end
endmodule

// File: rtl/mesi_snoop_resp.sv
module mesi_snoop_resp
    import mesi_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     snp_valid,
    input  logic     snp_rdx,
    input  logic     line_hit,
    input  line_st_t line_st,
    output logic     upd_en,
    output line_st_t upd_st,
    output logic     snp_shared,
    output logic     snp_flush,
    output logic     snp_c2c
);
    logic shared_d, flush_d, c2c_d;

    always_comb begin
        upd_en   = 1'b0;
        upd_st   = line_st;
        shared_d = 1'b0;
        flush_d  = 1'b0;
        c2c_d    = 1'b0;
        if (snp_valid && line_hit) begin
            if (snp_rdx) begin
                upd_en  = 1'b1;
                upd_st  = LN_I;
                flush_d = (line_st == LN_M);
            end else begin
                shared_d = 1'b1;
                unique case (line_st)
                    LN_M: begin upd_en = 1'b1; upd_st = LN_S; flush_d = 1'b1; end
                    LN_E: begin upd_en = 1'b1; upd_st = LN_S; c2c_d   = 1'b1; end
                    LN_S, LN_I: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snp_shared <= 1'b0;
            snp_flush  <= 1'b0;
            snp_c2c    <= 1'b0;
        end else begin
            snp_shared <= shared_d;
            snp_flush  <= flush_d;
            snp_c2c    <= c2c_d;
        end
    end

    assert_flush_c2c_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(snp_flush && snp_c2c));
    assert_c2c_shared_R6: assert property (@(posedge clk) disable iff (!rst_n)
        snp_c2c |-> snp_shared);
    assert_resp_needs_snoop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_shared || snp_flush || snp_c2c) |-> $past(snp_valid));
endmodule

// File: rtl/mesi_cpu_fsm.sv
module mesi_cpu_fsm
    import mesi_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int SETS    = 8,
    parameter int RSP_LAT = 2,
    localparam int IDX_W = $clog2(SETS),
    localparam int TAG_W = ADDR_W - IDX_W,
    localparam int CNT_W = $clog2(RSP_LAT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_valid,
    input  logic              cpu_req_write,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  logic              snp_valid,
    input  logic              bus_shared_in,
    input  line_st_t          cur_st,
    input  logic [TAG_W-1:0]  cur_tag,
    output logic              cpu_ready,
    output logic              cpu_done,
    output logic              bus_req_valid,
    output logic              bus_req_rdx,
    output logic [ADDR_W-1:0] bus_req_addr,
    output logic              wb_req,
    output logic [ADDR_W-1:0] wb_addr,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output line_st_t          wr_st,
    output logic              wr_tag_en,
    output logic [TAG_W-1:0]  wr_tag
);
    fsm_st_t           fsm_q, fsm_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [IDX_W-1:0]  pend_q, pend_d;
    logic              done_d, bv_d, rdx_d, wb_d;
    logic [ADDR_W-1:0] baddr_d, wbaddr_d;
    logic [IDX_W-1:0]  req_idx;
    logic [TAG_W-1:0]  req_tag;
    logic              accept, hit;

    assign req_idx   = cpu_req_addr[IDX_W-1:0];
    assign req_tag   = cpu_req_addr[ADDR_W-1:IDX_W];
    assign cpu_ready = (fsm_q == FS_IDLE) && !snp_valid;
    assign accept    = cpu_ready && cpu_req_valid;
    assign hit       = (cur_st != LN_I) && (cur_tag == req_tag);

    always_comb begin
        fsm_d     = fsm_q;
        cnt_d     = cnt_q;
        pend_d    = pend_q;
        done_d    = 1'b0;
        bv_d      = 1'b0;
        rdx_d     = 1'b0;
        wb_d      = 1'b0;
        baddr_d   = bus_req_addr;
        wbaddr_d  = wb_addr;
        wr_en     = 1'b0;
        wr_idx    = req_idx;
        wr_st     = LN_I;
        wr_tag_en = 1'b0;
        wr_tag    = req_tag;
        unique case (fsm_q)
            FS_RESP: begin
                if (cnt_q == CNT_W'(RSP_LAT - 1)) begin
                    wr_en  = 1'b1;
                    wr_idx = pend_q;
                    wr_st  = bus_shared_in ? LN_S : LN_E;
                    done_d = 1'b1;
                    fsm_d  = FS_IDLE;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            FS_IDLE: begin
                if (accept) begin
                    if (hit) begin
                        if (cpu_req_write) begin
                            wr_en  = 1'b1;
                            wr_st  = LN_M;
                            done_d = 1'b1;
                            if (cur_st == LN_S) begin
                                bv_d    = 1'b1;
                                rdx_d   = 1'b1;
                                baddr_d = cpu_req_addr;
                            end
                        end else begin
                            done_d = 1'b1;
                        end
                    end else begin
                        if (cur_st == LN_M) begin
                            wb_d     = 1'b1;
                            wbaddr_d = {cur_tag, req_idx};
                        end
                        bv_d      = 1'b1;
                        rdx_d     = cpu_req_write;
                        baddr_d   = cpu_req_addr;
                        wr_en     = 1'b1;
                        wr_tag_en = 1'b1;
                        if (cpu_req_write) begin
                            wr_st  = LN_M;
                            done_d = 1'b1;
                        end else begin
                            wr_st  = LN_I;
                            pend_d = req_idx;
                            cnt_d  = '0;
                            fsm_d  = FS_RESP;
                        end
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm_q         <= FS_IDLE;
            cnt_q         <= '0;
            pend_q        <= '0;
            cpu_done      <= 1'b0;
            bus_req_valid <= 1'b0;
            bus_req_rdx   <= 1'b0;
            bus_req_addr  <= '0;
            wb_req        <= 1'b0;
            wb_addr       <= '0;
        end else begin
            fsm_q         <= fsm_d;
            cnt_q         <= cnt_d;
            pend_q        <= pend_d;
            cpu_done      <= done_d;
            bus_req_valid <= bv_d;
            bus_req_rdx   <= rdx_d;
            bus_req_addr  <= baddr_d;
            wb_req        <= wb_d;
            wb_addr       <= wbaddr_d;
        end
    end

    assert_bus_needs_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_valid |-> $past(cpu_req_valid));
    assert_wb_with_miss_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req |-> bus_req_valid);
    assert_snoop_first_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(snp_valid) && $past(fsm_q == FS_IDLE)) |-> !bus_req_valid);
endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl
    import mesi_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int SETS    = 8,
    parameter int RSP_LAT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_valid,
    input  logic              cpu_req_write,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    output logic              cpu_ready,
    output logic              cpu_done,
    output logic              bus_req_valid,
    output logic              bus_req_rdx,
    output logic [ADDR_W-1:0] bus_req_addr,
    input  logic              bus_shared_in,
    input  logic              snp_valid,
    input  logic              snp_rdx,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_shared,
    output logic              snp_flush,
    output logic              snp_c2c,
    output logic              wb_req,
    output logic [ADDR_W-1:0] wb_addr
);
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - IDX_W;

    line_st_t         a_st, b_st, a_wst, b_wst;
    logic [TAG_W-1:0] a_tag, b_tag, a_wtag;
    logic [IDX_W-1:0] a_widx;
    logic             a_we, a_wtag_en, b_we, snp_hit;

    assign snp_hit = (b_st != LN_I) && (b_tag == snp_addr[ADDR_W-1:IDX_W]);

    mesi_line_store #(.SETS(SETS), .TAG_W(TAG_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .a_idx(cpu_req_addr[IDX_W-1:0]), .a_st(a_st), .a_tag(a_tag),
        .b_idx(snp_addr[IDX_W-1:0]), .b_st(b_st), .b_tag(b_tag),
        .b_we(b_we), .b_wst(b_wst),
        .a_we(a_we), .a_widx(a_widx), .a_wst(a_wst),
        .a_wtag_en(a_wtag_en), .a_wtag(a_wtag)
    );

    mesi_snoop_resp u_snoop (
        .clk(clk), .rst_n(rst_n),
        .snp_valid(snp_valid), .snp_rdx(snp_rdx),
        .line_hit(snp_hit), .line_st(b_st),
        .upd_en(b_we), .upd_st(b_wst),
        .snp_shared(snp_shared), .snp_flush(snp_flush), .snp_c2c(snp_c2c)
    );

    mesi_cpu_fsm #(.ADDR_W(ADDR_W), .SETS(SETS), .RSP_LAT(RSP_LAT)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_valid(cpu_req_valid), .cpu_req_write(cpu_req_write),
        .cpu_req_addr(cpu_req_addr), .snp_valid(snp_valid),
        .bus_shared_in(bus_shared_in),
        .cur_st(a_st), .cur_tag(a_tag),
        .cpu_ready(cpu_ready), .cpu_done(cpu_done),
        .bus_req_valid(bus_req_valid), .bus_req_rdx(bus_req_rdx),
        .bus_req_addr(bus_req_addr),
        .wb_req(wb_req), .wb_addr(wb_addr),
        .wr_en(a_we), .wr_idx(a_widx), .wr_st(a_wst),
        .wr_tag_en(a_wtag_en), .wr_tag(a_wtag)
    );
endmodule

// File: tb/mesi_snoop_ctrl_bench.sv
module mesi_snoop_ctrl_bench;
    localparam int AW = 8;
    localparam int NS = 8;
    localparam int LAT = 2;
    // model state codes: 0 I, 1 S, 2 E, 3 M
    localparam int CI = 0, CS = 1, CE = 2, CM = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_req_valid = 1'b0, cpu_req_write = 1'b0;
    logic [AW-1:0] cpu_req_addr = '0;
    logic cpu_ready, cpu_done, bus_req_valid, bus_req_rdx;
    logic [AW-1:0] bus_req_addr, wb_addr, snp_addr = '0;
    logic bus_shared_in = 1'b0, snp_valid = 1'b0, snp_rdx = 1'b0;
    logic snp_shared, snp_flush, snp_c2c, wb_req;

    mesi_snoop_ctrl #(.ADDR_W(AW), .SETS(NS), .RSP_LAT(LAT)) u_mesi_snoop_ctrl (.*);

    always #5 clk = ~clk;

    int m_st [NS];
    int m_tag[NS];
    int busy, cnt, pidx;
    int e_done, e_bv, e_rdx, e_baddr, e_wb, e_wbaddr, e_sh, e_fl, e_c2c;
    int n_cmp = 0, n_bad = 0, cycles = 0;

    // behavioural reference, stepped on every rising edge
    always @(posedge clk) begin
        int si, stg, ci, ctg, hit;
        e_done = 0; e_bv = 0; e_rdx = 0; e_wb = 0; e_sh = 0; e_fl = 0; e_c2c = 0;
        if (!rst_n) begin
            for (int i = 0; i < NS; i++) begin m_st[i] = CI; m_tag[i] = 0; end
            busy = 0; cnt = 0; pidx = 0; e_baddr = 0; e_wbaddr = 0;
        end else begin
            if (snp_valid) begin
                si = snp_addr % NS; stg = snp_addr / NS;
                if (m_st[si] != CI && m_tag[si] == stg) begin
                    if (snp_rdx) begin
                        if (m_st[si] == CM) e_fl = 1;
                        m_st[si] = CI;
                    end else begin
                        e_sh = 1;
                        if (m_st[si] == CM) e_fl = 1;
                        if (m_st[si] == CE) e_c2c = 1;
                        m_st[si] = CS;
                    end
                end
            end
            if (busy) begin
                cnt++;
                if (cnt == LAT) begin
                    m_st[pidx] = bus_shared_in ? CS : CE;
                    e_done = 1; busy = 0;
                end
            end else if (cpu_req_valid && !snp_valid) begin
                ci = cpu_req_addr % NS; ctg = cpu_req_addr / NS;
                hit = (m_st[ci] != CI && m_tag[ci] == ctg);
                if (hit) begin
                    e_done = 1;
                    if (cpu_req_write) begin
                        if (m_st[ci] == CS) begin e_bv = 1; e_rdx = 1; e_baddr = cpu_req_addr; end
                        m_st[ci] = CM;
                    end
                end else begin
                    if (m_st[ci] == CM) begin e_wb = 1; e_wbaddr = m_tag[ci] * NS + ci; end
                    e_bv = 1; e_rdx = cpu_req_write; e_baddr = cpu_req_addr;
                    m_tag[ci] = ctg;
                    if (cpu_req_write) begin m_st[ci] = CM; e_done = 1; end
                    else begin m_st[ci] = CI; busy = 1; cnt = 0; pidx = ci; end
                end
            end
        end
    end

    task automatic cmp(input string req, input string nm, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", req, nm, act, exp, cycles);
        end
    endtask

    // compare on every falling edge
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            cmp("R3", "cpu_done", int'(cpu_done), e_done);
            cmp("R2", "bus_req_valid", int'(bus_req_valid), e_bv);
            cmp("R5", "bus_req_rdx", int'(bus_req_rdx), e_rdx);
            if (e_bv != 0) cmp("R2", "bus_req_addr", int'(bus_req_addr), e_baddr);
            cmp("R10", "wb_req", int'(wb_req), e_wb);
            if (e_wb != 0) cmp("R10", "wb_addr", int'(wb_addr), e_wbaddr);
            cmp("R6", "snp_shared", int'(snp_shared), e_sh);
            cmp("R7", "snp_flush", int'(snp_flush), e_fl);
            cmp("R8", "snp_c2c", int'(snp_c2c), e_c2c);
            cmp("R12", "cpu_ready", int'(cpu_ready), int'(busy == 0 && !snp_valid));
        end
        if (cycles > 20000) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic cpu_op(input bit wr, input int addr, input bit shr);
        @(negedge clk);
        cpu_req_valid = 1'b1; cpu_req_write = wr; cpu_req_addr = AW'(addr);
        bus_shared_in = shr;
        @(negedge clk);
        cpu_req_valid = 1'b0;
        repeat (LAT + 2) @(negedge clk);
        bus_shared_in = 1'b0;
    endtask

    task automatic snoop(input bit rdx, input int addr);
        @(negedge clk);
        snp_valid = 1'b1; snp_rdx = rdx; snp_addr = AW'(addr);
        @(negedge clk);
        snp_valid = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1: fresh lines miss
        cpu_op(0, 8'h01, 0);
        cpu_op(0, 8'h03, 1);
        // R2 fill Exclusive, R3 hit, R4 silent upgrade
        cpu_op(0, 8'h05, 0);
        cpu_op(0, 8'h05, 0);
        cpu_op(1, 8'h05, 0);
        // R6 + R7: Modified snooped by read -> flush, Shared
        snoop(0, 8'h05);
        // R5: upgrade from Shared
        cpu_op(1, 8'h05, 0);
        // R9: Modified snooped by read-for-ownership -> flush, Invalid
        snoop(1, 8'h05);
        cpu_op(0, 8'h05, 1);
        // Shared line: read snoop only shared, rdx silent invalidate (R8, R9)
        snoop(0, 8'h05);
        snoop(1, 8'h05);
        cpu_op(0, 8'h05, 0);
        // R8: Exclusive snooped by read -> c2c
        cpu_op(0, 8'h02, 0);
        snoop(0, 8'h02);
        // R5 write miss, R10 dirty eviction then clean eviction
        cpu_op(1, 8'h0A, 0);
        cpu_op(0, 8'h12, 0);
        cpu_op(0, 8'h1A, 1);
        cpu_op(0, 8'h12, 0);
        // R11: snoop to other tag on same index, and to Invalid index
        snoop(0, 8'h22);
        snoop(1, 8'h27);
        cpu_op(0, 8'h12, 0);
        // R12: request during snoop is dropped
        @(negedge clk);
        snp_valid = 1'b1; snp_rdx = 1'b0; snp_addr = 8'h30;
        cpu_req_valid = 1'b1; cpu_req_write = 1'b1; cpu_req_addr = 8'h31;
        @(negedge clk);
        snp_valid = 1'b0; cpu_req_valid = 1'b0;
        repeat (3) @(negedge clk);
        // R12: request while a BusRd is outstanding is dropped
        @(negedge clk);
        cpu_req_valid = 1'b1; cpu_req_write = 1'b0; cpu_req_addr = 8'h04;
        @(negedge clk);
        cpu_req_addr = 8'h06;
        @(negedge clk);
        cpu_req_valid = 1'b0;
        repeat (4) @(negedge clk);
        // R4 on Exclusive from a previous fill, then R10 dirty eviction of it
        cpu_op(1, 8'h04, 0);
        cpu_op(0, 8'h0C, 0);
        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule